// File: doc/BRIEF.md
# Decimal Recoded Partial Product Generator

This block forms one partial product of a parallel decimal multiplier. It takes an N-digit BCD multiplicand and a single BCD multiplier digit. It returns the product of the two as an (N+2)-digit BCD word after one register stage. The block does not build every multiple from 1X to 9X. Instead it splits the digit into a high part worth five and a low part. The high part has weight 0, 5 or 10, and the low part is a signed value from -2 to +2. Each part picks one ready multiple. The two multiples are then added, or subtracted by ten's complement.

The multiples 2X and 5X come from digit-local rules, with no carry between digits. 10X is a one-digit shift of X. A negative low part takes the nine's complement of every digit of the chosen multiple, and a +1 enters the carry-in of the decimal adder. The output flag tells the shifting and reduction stages downstream that the subtract path was used. Shifting, reducing several partial products and forming the final product are done outside this block.

The block has no state machine. Its only state is the output register, which loads whenever the input strobe is high. The register idles with a zero word. The block has two conditions: hold, when the strobe is low, and load, when the strobe is high.

Top module: `dpp_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `pp_sub` and every bit of `pp_digits` are 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `pp_digits` and `pp_sub` for that input are on the ports in that same cycle.
- R3: For a BCD multiplicand X (digit k in bits 4k+3:4k, least significant digit in bits 3:0) and a digit d in 0..9, `pp_digits` equals d·X as N+2 BCD digits, using the same digit order.
- R4: `pp_sub` is 1 for digit values 3, 4, 8 and 9, where the low part of the recoding is negative. It is 0 for digits 0, 1, 2, 5, 6 and 7.
- R5: Digit codes 10 to 15 are treated as zero: the loaded `pp_digits` is 0 and `pp_sub` is 0.
- R6: While `in_valid` is low, `pp_digits` and `pp_sub` keep their last loaded values, whatever the other inputs do.
- R7: Every loaded output digit is a legal BCD digit (0 to 9), and the most significant output digit is always 0.
- R8: The extreme cases are exact: an all-nines multiplicand times 9 and times 8, a zero multiplicand with any digit, and a multiplicand of 1 with every digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load strobe for multiplicand and digit |
| multiplicand | input | 4*DIGITS | BCD multiplicand X, digit 0 in the low nibble |
| mult_digit | input | 4 | BCD multiplier digit d |
| out_valid | output | 1 | Partial product register loaded in previous cycle |
| pp_digits | output | 4*(DIGITS+2) | BCD partial product d·X |
| pp_sub | output | 1 | Low multiple was subtracted (ten's complement path) |

## Verification
A wrong recoding or a wrong multiple selection shows on `pp_digits` one cycle after the strobe. For some digit values the digits are off, and a flipped sign decision also flips `pp_sub` in that same cycle. A fault in the carry-free 2X or 5X rules or in the complement path shows as a non-BCD digit, as a wrong carry out of the top digit, or as a nonzero top digit. All of these appear on the first load that uses the affected multiple. Every digit value is therefore applied across many multiplicands, including ones with every digit at 5 or above, where each digit-local borrow rule fires.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

    typedef logic [3:0] bcd_t;

    typedef enum logic [1:0] {
        UP_ZERO = 2'd0,
        UP_FIVE = 2'd1,
        UP_TEN  = 2'd2
    } upper_sel_e;

    typedef enum logic [1:0] {
        LO_ZERO = 2'd0,
        LO_ONE  = 2'd1,
        LO_TWO  = 2'd2
    } lower_mag_e;

    typedef struct packed {
        upper_sel_e up;
        lower_mag_e lo;
        logic       neg;
    } recode_t;

    function automatic bcd_t nines_comp(input bcd_t v);
        return bcd_t'(4'd9 - v);
    endfunction

endpackage

// File: rtl/dpp_recode.sv
module dpp_recode
    import dpp_pkg::*;
(
    input  logic [3:0] digit,
    output recode_t    code
);

    always_comb begin
        code = '{up: UP_ZERO, lo: LO_ZERO, neg: 1'b0};
        unique case (digit)
            4'd0: code = '{up: UP_ZERO, lo: LO_ZERO, neg: 1'b0};
            4'd1: code = '{up: UP_ZERO, lo: LO_ONE,  neg: 1'b0};
            4'd2: code = '{up: UP_ZERO, lo: LO_TWO,  neg: 1'b0};
            4'd3: code = '{up: UP_FIVE, lo: LO_TWO,  neg: 1'b1};
            4'd4: code = '{up: UP_FIVE, lo: LO_ONE,  neg: 1'b1};
            4'd5: code = '{up: UP_FIVE, lo: LO_ZERO, neg: 1'b0};
            4'd6: code = '{up: UP_FIVE, lo: LO_ONE,  neg: 1'b0};
            4'd7: code = '{up: UP_FIVE, lo: LO_TWO,  neg: 1'b0};
            4'd8: code = '{up: UP_TEN,  lo: LO_TWO,  neg: 1'b1};
            4'd9: code = '{up: UP_TEN,  lo: LO_ONE,  neg: 1'b1};
            default: code = '{up: UP_ZERO, lo: LO_ZERO, neg: 1'b0};
        endcase
    end

endmodule

// File: rtl/dpp_multiples.sv
module dpp_multiples #(
    parameter int DIGITS = 8
) (
    input  logic [4*DIGITS-1:0]     x,
    output logic [4*(DIGITS+1)-1:0] x1,
    output logic [4*(DIGITS+1)-1:0] x2,
    output logic [4*(DIGITS+1)-1:0] x5,
    output logic [4*(DIGITS+1)-1:0] x10
);

    localparam int EXT = DIGITS + 2;

    logic [4*EXT-1:0] xe;

    assign xe = {4'h0, x, 4'h0};
    assign x1 = {4'h0, x};

    for (genvar i = 0; i <= DIGITS; i++) begin : g_dig
        logic [3:0] cur;
        logic [3:0] prev;
        logic [4:0] dbl;
        logic [3:0] dbl_mod;

        assign cur  = xe[4*(i+1) +: 4];
        assign prev = xe[4*i +: 4];
        assign dbl  = {cur, 1'b0};

        always_comb begin
            dbl_mod = (dbl >= 5'd10) ? 4'(dbl - 5'd10) : dbl[3:0];
        end

        assign x2[4*i +: 4]  = dbl_mod + {3'b000, (prev >= 4'd5)};
        assign x5[4*i +: 4]  = (cur[0] ? 4'd5 : 4'd0) + {1'b0, prev[3:1]};
        assign x10[4*i +: 4] = prev;
    end

endmodule

// File: rtl/dpp_select_add.sv
module dpp_select_add
    import dpp_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  recode_t                   code,
    input  logic [4*(DIGITS+1)-1:0]   x1,
    input  logic [4*(DIGITS+1)-1:0]   x2,
    input  logic [4*(DIGITS+1)-1:0]   x5,
    input  logic [4*(DIGITS+1)-1:0]   x10,
    output logic [4*(DIGITS+2)-1:0]   sum,
    output logic                      carry_out
);

    localparam int PD = DIGITS + 2;
    localparam int PW = 4 * PD;

    logic [PW-1:0] op_up;
    logic [PW-1:0] mag_lo;
    logic [PW-1:0] op_lo;
    logic [PD:0]   cy;

    always_comb begin
        unique case (code.up)
            UP_FIVE: op_up = {4'h0, x5};
            UP_TEN:  op_up = {4'h0, x10};
            default: op_up = '0;
        endcase
        unique case (code.lo)
            LO_ONE:  mag_lo = {4'h0, x1};
            LO_TWO:  mag_lo = {4'h0, x2};
            default: mag_lo = '0;
        endcase
    end

    assign cy[0] = code.neg;

    for (genvar i = 0; i < PD; i++) begin : g_add
        logic [4:0] raw;

        assign op_lo[4*i +: 4] = code.neg ? nines_comp(mag_lo[4*i +: 4])
                                          : mag_lo[4*i +: 4];
        assign raw = {1'b0, op_up[4*i +: 4]} + {1'b0, op_lo[4*i +: 4]}
                   + {4'b0000, cy[i]};

        always_comb begin
            if (raw >= 5'd10) begin
                sum[4*i +: 4] = 4'(raw - 5'd10);
                cy[i+1]       = 1'b1;
            end else begin
                sum[4*i +: 4] = raw[3:0];
                cy[i+1]       = 1'b0;
            end
        end
    end

    assign carry_out = cy[PD];

endmodule

// File: rtl/dpp_gen.sv
module dpp_gen
    import dpp_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [4*DIGITS-1:0]     multiplicand,
    input  logic [3:0]              mult_digit,
    output logic                    out_valid,
    output logic [4*(DIGITS+2)-1:0] pp_digits,
    output logic                    pp_sub
);

    localparam int XW = 4 * (DIGITS + 1);
    localparam int PW = 4 * (DIGITS + 2);

    recode_t       code;
    logic [XW-1:0] m1, m2, m5, m10;
    logic [PW-1:0] sum_w;
    logic          carry_w;

    dpp_recode u_recode (
        .digit (mult_digit),
        .code  (code)
    );

    dpp_multiples #(.DIGITS(DIGITS)) u_mult (
        .x   (multiplicand),
        .x1  (m1),
        .x2  (m2),
        .x5  (m5),
        .x10 (m10)
    );

    dpp_select_add #(.DIGITS(DIGITS)) u_add (
        .code      (code),
        .x1        (m1),
        .x2        (m2),
        .x5        (m5),
        .x10       (m10),
        .sum       (sum_w),
        .carry_out (carry_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pp_digits <= '0;
            pp_sub    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                pp_digits <= sum_w;
                pp_sub    <= code.neg;
            end
        end
    end

    function automatic logic x_is_bcd(input logic [4*DIGITS-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < DIGITS; k++) begin
            if (v[4*k +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic pp_is_bcd(input logic [PW-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < DIGITS + 2; k++) begin
            if (v[4*k +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pp_digits) && $stable(pp_sub)));  // R6
    AST_SUB_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code.neg && x_is_bcd(multiplicand)) |-> carry_w);  // R3
    AST_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !code.neg && x_is_bcd(multiplicand)) |-> !carry_w);  // R3
    AST_OUT_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_is_bcd(multiplicand)) |=> pp_is_bcd(pp_digits));  // R7
    AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_is_bcd(multiplicand)) |=> (pp_digits[PW-1 -: 4] == 4'd0));  // R7
    AST_BAD_DIGIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mult_digit > 4'd9) |=> (pp_digits == '0 && !pp_sub));  // R5

endmodule

// File: tb/sim_dpp_gen.sv
module sim_dpp_gen;

    localparam int D  = 8;
    localparam int XW = 4 * D;
    localparam int PW = 4 * (D + 2);
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [XW-1:0] multiplicand = '0;
    logic [3:0]    mult_digit = '0;
    logic          out_valid;
    logic [PW-1:0] pp_digits;
    logic          pp_sub;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dpp_gen #(.DIGITS(D)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .multiplicand (multiplicand),
        .mult_digit   (mult_digit),
        .out_valid    (out_valid),
        .pp_digits    (pp_digits),
        .pp_sub       (pp_sub)
    );

    localparam logic [XW+3:0] VEC [NV] = '{
        {32'h12345678, 4'd7}, {32'h99999999, 4'd9}, {32'h55555555, 4'd3},
        {32'h00000001, 4'd4}, {32'h98765432, 4'd8}, {32'h50505050, 4'd6},
        {32'h00000000, 4'd9}, {32'h19191919, 4'd2}, {32'h77777777, 4'd5},
        {32'h31415926, 4'd1}, {32'h66666666, 4'd0}, {32'h89898989, 4'd9}
    };

    function automatic longint bcd2int(input logic [XW-1:0] v);
        longint r = 0;
        for (int k = D - 1; k >= 0; k--) r = r * 10 + longint'(v[4*k +: 4]);
        return r;
    endfunction

    function automatic logic [PW-1:0] int2bcd(input longint v);
        logic [PW-1:0] r = '0;
        longint t = v;
        for (int k = 0; k < D + 2; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic exp_sub(input logic [3:0] d);
        return (d == 4'd3) || (d == 4'd4) || (d == 4'd8) || (d == 4'd9);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [XW-1:0] x, input logic [3:0] d);
        @(negedge clk);
        in_valid     = 1'b1;
        multiplicand = x;
        mult_digit   = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic apply_check(input string req, input logic [XW-1:0] x, input logic [3:0] d);
        longint prod;
        apply(x, d);
        prod = (d <= 4'd9) ? bcd2int(x) * longint'(d) : 0;
        check({req, " out_valid"}, 64'(out_valid), 64'd1);
        check({req, " product"}, 64'(pp_digits), 64'(int2bcd(prod)));
        check({req, " sub flag"}, 64'(pp_sub), (d <= 4'd9) ? 64'(exp_sub(d)) : 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [PW-1:0] held;
        logic          held_sub;
        logic [XW-1:0] rx;
        logic [XW-1:0] nines;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 pp_digits", 64'(pp_digits), 64'd0);
        check("R1 pp_sub", 64'(pp_sub), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle out_valid", 64'(out_valid), 64'd0);

        // R3 R4: table walk
        for (int v = 0; v < NV; v++) begin
            apply_check("R3 R4 table", VEC[v][XW+3:4], VEC[v][3:0]);
        end

        // R3 R4 R7: all ten digits over random multiplicands
        for (int r = 0; r < 30; r++) begin
            for (int k = 0; k < D; k++) rx[4*k +: 4] = 4'($urandom_range(9));
            for (int d = 0; d < 10; d++) apply_check("R3 R7 random", rx, 4'(d));
        end

        // R8: extremes
        nines = {D{4'h9}};
        apply_check("R8 nines x9", nines, 4'd9);
        apply_check("R8 nines x8", nines, 4'd8);
        for (int d = 0; d < 10; d++) apply_check("R8 zero X", '0, 4'(d));
        for (int d = 0; d < 10; d++) apply_check("R8 unit X", XW'(1), 4'(d));

        // R5: illegal digit codes
        for (int d = 10; d < 16; d++) apply_check("R5 bad digit", 32'h87654321, 4'(d));

        // R6: hold while strobe low
        apply(32'h24681357, 4'd9);
        held     = pp_digits;
        held_sub = pp_sub;
        multiplicand = 32'h11111111;
        mult_digit   = 4'd2;
        @(negedge clk);
        multiplicand = 32'h99999999;
        mult_digit   = 4'd7;
        @(negedge clk);
        check("R6 hold digits", 64'(pp_digits), 64'(held));
        check("R6 hold sub", 64'(pp_sub), 64'(held_sub));
        check("R2 no strobe", 64'(out_valid), 64'd0);

        // R2: back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1;
        multiplicand = 32'h00000123;
        mult_digit = 4'd4;
        @(negedge clk);
        check("R2 first", 64'(pp_digits), 64'(int2bcd(123 * 4)));
        multiplicand = 32'h00000456;
        mult_digit = 4'd8;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second", 64'(pp_digits), 64'(int2bcd(456 * 8)));
        check("R2 second valid", 64'(out_valid), 64'd1);

        // R1: reset mid-run clears
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset digits", 64'(pp_digits), 64'd0);
        check("R1 re-reset sub", 64'(pp_sub), 64'd0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule